// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block holds the host-visible command and control registers of a single-drive ATA disk interface on an 8-bit I/O bus. The host writes the sector count, block address bytes and device/head byte, then writes a command code. The block works out the starting block in cylinder/head/sector, 28-bit or 48-bit form, checks the request against the drive capacity, and either reports an out-of-range error or starts a separate data engine with a block address, a sector count and a direction.

The block keeps the status byte, including a status value that is held back until the host next reads status. It also raises the interrupt line, which the device-control register can mask, and sets a bus-master interrupt flag. A write to device control can apply a soft reset that loads a device signature into the address registers. Each count and address register keeps the byte written before the current one, and the 48-bit forms draw their upper bytes from that history.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset the status reads 0x50, the count, error, address and device/head registers read 0x00, the interrupt is masked (device-control bit 1 set), and irq, bmIntFlag and startReq are low.
- R2: Each write to the feature, sector-count, LBA-low, LBA-mid or LBA-high register moves the old low byte into a high byte. A read returns the newest byte.
- R3: With device/head bit 6 set, a 28-bit command starts at block {LBA-high, LBA-mid, LBA-low}, using the newest bytes only.
- R4: With device/head bit 6 clear, the start block is (cylinder × HEADS + head) × SECT_PER_TRACK + sector − 1. Here cylinder is {LBA-high, LBA-mid}, sector is LBA-low and head is device/head bits 3:0.
- R5: A 48-bit command starts at {previous LBA-low byte, LBA-high, LBA-mid, LBA-low} and takes the full 16-bit count. A count of zero means 256 sectors for 28-bit commands (0x20, 0xC4, 0x30) and 65536 sectors for 48-bit commands (0x24, 0x29, 0x34, 0x39).
- R6: If start block plus sector count exceeds CAPACITY, status becomes 0xFF, the interrupt is raised and no start request is issued. A request that ends exactly at CAPACITY is accepted.
- R7: An accepted read command sets status to 0x80 and pulses startReq for one cycle, with startLba, startCount and startWrite=0. The next xferDone sets status to 0x58 and raises the interrupt.
- R8: An accepted write command sets status to 0x50, pulses startReq with startWrite=1 and raises the interrupt. The following read of status (address 7) returns 0x50 and then installs 0x58. The next xferDone sets status to 0x50 and raises the interrupt.
- R9: A device-control write (address 0xE) with bit 2 set makes status 0x51, sector count 0x01 and LBA-low 0x01. It loads LBA-mid/LBA-high with 0x3C/0xC3, or with 0x14/0xEB when PACKET_DEV is 1.
- R10: The interrupt is raised only while device-control bit 1 is clear. A read of status at address 7 clears it, and a read of alternate status at address 0xE changes neither irq nor the pending status.
- R11: Each raised interrupt also sets bmIntFlag. The flag stays set until bmIntClr is pulsed.
- R12: A device/head write with bit 4 set is ignored. Any other device/head write is stored and read back at address 6.
- R13: An unknown command code makes the error register (read at address 1) 0x04 with no interrupt. Command 0x90 makes the error register 0x01, status 0x50, and raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 4 | Register index: 1..7 command block, 0xE control/alternate status |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| xferDone | input | 1 | Data engine finished the started request |
| bmIntClr | input | 1 | Clears the bus-master interrupt flag |
| startReq | output | 1 | One-cycle start pulse toward the data engine |
| startLba | output | 32 | Starting block of the request |
| startCount | output | 17 | Sector count of the request (1..65536) |
| startWrite | output | 1 | Request direction, 1 = write |
| irq | output | 1 | Interrupt line |
| bmIntFlag | output | 1 | Bus-master status interrupt bit |

## Verification
The address logic is tested in three ways: an LBA28 read with distinct bytes in each register, a CHS request with a non-zero cylinder and head, and 48-bit requests. Together these show whether the head bits or the byte history leak into the wrong form. Two sector counts are run against a start block just below capacity, which separates a correct inclusive range check from an off-by-one. A count of zero is tried in both widths. A 48-bit request with a stale non-zero low byte must be rejected, while the same registers must be accepted by a 28-bit command. Alternate-status reads placed between status reads show that the pending status and the interrupt change only on the real status read.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam logic [7:0] ST_READY = 8'h50;
  localparam logic [7:0] ST_DRQ   = 8'h58;
  localparam logic [7:0] ST_BUSY  = 8'h80;
  localparam logic [7:0] ST_RANGE = 8'hFF;
  localparam logic [7:0] ST_SRST  = 8'h51;

  localparam logic [3:0] A_ERRFEAT = 4'h1;
  localparam logic [3:0] A_COUNT   = 4'h2;
  localparam logic [3:0] A_LOW     = 4'h3;
  localparam logic [3:0] A_MID     = 4'h4;
  localparam logic [3:0] A_HIGH    = 4'h5;
  localparam logic [3:0] A_DRIVE   = 4'h6;
  localparam logic [3:0] A_CMD     = 4'h7;
  localparam logic [3:0] A_CTL     = 4'hE;

  typedef enum logic [2:0] {
    CK_RD28, CK_RD48, CK_WR28, CK_WR48, CK_DIAG, CK_NOP, CK_ACK, CK_BAD
  } cmdKind_t;

  typedef struct packed {
    logic wrFeat;
    logic wrCount;
    logic wrLow;
    logic wrMid;
    logic wrHigh;
    logic wrDrive;
    logic loadSig;
    logic setDiag;
    logic setAbort;
  } tfStrobes_t;

  function automatic cmdKind_t decodeCmd(input logic [7:0] code);
    case (code)
      8'h20, 8'hC4:        return CK_RD28;
      8'h24, 8'h29:        return CK_RD48;
      8'h30:               return CK_WR28;
      8'h34, 8'h39:        return CK_WR48;
      8'h90:               return CK_DIAG;
      8'h00, 8'h08:        return CK_NOP;
      8'h10, 8'h91, 8'hE1,
      8'hEA, 8'hEF:        return CK_ACK;
      default:             return CK_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int HEADS          = 16,
  parameter int SECT_PER_TRACK = 63,
  parameter int CAPACITY       = 65536,
  parameter bit PACKET_DEV     = 1'b0,
  parameter int LBA_W          = 32,
  parameter int CNT_W          = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  tfStrobes_t       str,
  input  logic [7:0]       wrData,
  input  logic [3:0]       rdAddr,
  input  logic [7:0]       statusIn,
  output logic [7:0]       rdData,
  output logic [LBA_W-1:0] addr28,
  output logic [LBA_W-1:0] addr48,
  output logic [CNT_W-1:0] cnt28,
  output logic [CNT_W-1:0] cnt48,
  output logic             oor28,
  output logic             oor48
);

  localparam logic [7:0] SIG_MID  = PACKET_DEV ? 8'h14 : 8'h3C;
  localparam logic [7:0] SIG_HIGH = PACKET_DEV ? 8'hEB : 8'hC3;

  logic [15:0] featErr, cntReg, lowReg, midReg, highReg;
  logic [7:0]  drvHead;
  logic        lbaMode;
  logic [3:0]  headNum;

  always_ff @(posedge clk) begin
    if (rst) begin
      featErr <= '0; cntReg <= '0; lowReg <= '0; midReg <= '0; highReg <= '0;
      drvHead <= '0; lbaMode <= 1'b0; headNum <= '0;
    end else begin
      if (str.wrFeat)  featErr <= {featErr[7:0], wrData};
      if (str.wrCount) cntReg  <= {cntReg[7:0], wrData};
      if (str.wrLow)   lowReg  <= {lowReg[7:0], wrData};
      if (str.wrMid)   midReg  <= {midReg[7:0], wrData};
      if (str.wrHigh)  highReg <= {highReg[7:0], wrData};
      if (str.wrDrive && !wrData[4]) begin
        drvHead <= wrData;
        lbaMode <= wrData[6];
        headNum <= wrData[3:0];
      end
      if (str.setDiag)  featErr <= 16'h0101;
      if (str.setAbort) featErr <= 16'h0004;
      if (str.loadSig) begin
        cntReg  <= 16'h0001;
        lowReg  <= 16'h0001;
        midReg  <= {8'h00, SIG_MID};
        highReg <= {8'h00, SIG_HIGH};
      end
    end
  end

  // address forms
  logic [LBA_W-1:0] lbaFlat, chsAddr;
  logic [15:0]      cylNum;
  always_comb begin
    cylNum  = {highReg[7:0], midReg[7:0]};
    lbaFlat = LBA_W'({highReg[7:0], midReg[7:0], lowReg[7:0]});
    chsAddr = (LBA_W'(cylNum) * LBA_W'(HEADS) + LBA_W'(headNum)) * LBA_W'(SECT_PER_TRACK)
              + LBA_W'(lowReg[7:0]) - LBA_W'(1);
    addr28  = lbaMode ? lbaFlat : chsAddr;
    addr48  = LBA_W'({lowReg[15:8], highReg[7:0], midReg[7:0], lowReg[7:0]});
    cnt28   = (cntReg[7:0] == 8'd0)  ? CNT_W'(256)   : CNT_W'(cntReg[7:0]);
    cnt48   = (cntReg == 16'd0)      ? CNT_W'(65536) : CNT_W'(cntReg);
    oor28   = ({1'b0, addr28} + (LBA_W+1)'(cnt28)) > (LBA_W+1)'(CAPACITY);
    oor48   = ({1'b0, addr48} + (LBA_W+1)'(cnt48)) > (LBA_W+1)'(CAPACITY);
  end

  always_comb begin
    case (rdAddr)
      A_ERRFEAT: rdData = featErr[7:0];
      A_COUNT:   rdData = cntReg[7:0];
      A_LOW:     rdData = lowReg[7:0];
      A_MID:     rdData = midReg[7:0];
      A_HIGH:    rdData = highReg[7:0];
      A_DRIVE:   rdData = drvHead;
      A_CMD,
      A_CTL:     rdData = statusIn;
      default:   rdData = 8'h00;
    endcase
  end

  // R12
  drive_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (str.wrDrive && wrData[4]) |=> $stable(drvHead));

  // R9
  sig_load_chk: assert property (@(posedge clk) disable iff (rst)
    str.loadSig |=> (cntReg == 16'h0001 && lowReg == 16'h0001 && midReg[7:0] == SIG_MID));

endmodule

// File: rtl/ata_tf_control.sv
module ata_tf_control
  import ata_tf_pkg::*;
#(
  parameter int LBA_W = 32,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [7:0]       busWrData,
  input  logic             xferDone,
  input  logic             bmIntClr,
  input  logic [LBA_W-1:0] addr28,
  input  logic [LBA_W-1:0] addr48,
  input  logic [CNT_W-1:0] cnt28,
  input  logic [CNT_W-1:0] cnt48,
  input  logic             oor28,
  input  logic             oor48,
  output tfStrobes_t       str,
  output logic [7:0]       statusQ,
  output logic             startReq,
  output logic [LBA_W-1:0] startLba,
  output logic [CNT_W-1:0] startCount,
  output logic             startWrite,
  output logic             irqQ,
  output logic             bmFlag
);

  logic [7:0] devCtl, nextStatus;
  logic       pendValid, opBusy, opRead;

  logic     cmdWr, ctlWr, stsRd, doneEv, isRead, isWrite, is48, oorSel, raise;
  cmdKind_t kind;

  always_comb begin
    cmdWr   = busWr && busAddr == A_CMD;
    ctlWr   = busWr && busAddr == A_CTL;
    stsRd   = busRd && busAddr == A_CMD;
    doneEv  = xferDone && opBusy;
    kind    = decodeCmd(busWrData);
    isRead  = kind == CK_RD28 || kind == CK_RD48;
    isWrite = kind == CK_WR28 || kind == CK_WR48;
    is48    = kind == CK_RD48 || kind == CK_WR48;
    oorSel  = is48 ? oor48 : oor28;
    raise   = doneEv || (cmdWr && kind != CK_BAD && !(isRead && !oorSel));

    str          = '0;
    str.wrFeat   = busWr && busAddr == A_ERRFEAT;
    str.wrCount  = busWr && busAddr == A_COUNT;
    str.wrLow    = busWr && busAddr == A_LOW;
    str.wrMid    = busWr && busAddr == A_MID;
    str.wrHigh   = busWr && busAddr == A_HIGH;
    str.wrDrive  = busWr && busAddr == A_DRIVE;
    str.loadSig  = ctlWr && busWrData[2];
    str.setDiag  = cmdWr && kind == CK_DIAG;
    str.setAbort = cmdWr && kind == CK_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= ST_READY; nextStatus <= ST_READY; pendValid <= 1'b0;
      devCtl <= 8'h02; irqQ <= 1'b0; bmFlag <= 1'b0;
      startReq <= 1'b0; startLba <= '0; startCount <= '0; startWrite <= 1'b0;
      opBusy <= 1'b0; opRead <= 1'b0;
    end else begin
      startReq <= 1'b0;
      if (stsRd) begin
        irqQ <= 1'b0;
        if (pendValid) begin
          statusQ   <= nextStatus;
          pendValid <= 1'b0;
        end
      end
      if (doneEv) begin
        opBusy  <= 1'b0;
        statusQ <= opRead ? ST_DRQ : ST_READY;
      end
      if (ctlWr) begin
        devCtl <= busWrData;
        if (busWrData[2]) begin
          statusQ   <= ST_SRST;
          pendValid <= 1'b0;
          opBusy    <= 1'b0;
        end
      end
      if (cmdWr) begin
        if (isRead || isWrite) begin
          if (oorSel) begin
            statusQ <= ST_RANGE;
          end else begin
            startReq   <= 1'b1;
            startLba   <= is48 ? addr48 : addr28;
            startCount <= is48 ? cnt48 : cnt28;
            startWrite <= isWrite;
            opBusy     <= 1'b1;
            opRead     <= isRead;
            if (isRead) begin
              statusQ <= ST_BUSY;
            end else begin
              statusQ    <= ST_READY;
              nextStatus <= ST_DRQ;
              pendValid  <= 1'b1;
            end
          end
        end else if (kind == CK_DIAG || kind == CK_NOP) begin
          statusQ <= ST_READY;
        end
      end
      if (raise && !devCtl[1]) begin
        irqQ   <= 1'b1;
        bmFlag <= 1'b1;
      end else if (bmIntClr) begin
        bmFlag <= 1'b0;
      end
    end
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (devCtl[1] && !irqQ) |=> !irqQ);

  // R11
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irqQ) |-> bmFlag);

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    startReq |=> !startReq);

  // R8
  next_status_chk: assert property (@(posedge clk) disable iff (rst)
    (stsRd && pendValid && !cmdWr && !ctlWr && !doneEv) |=> statusQ == $past(nextStatus));

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_tf_pkg::*;
#(
  parameter int HEADS          = 16,
  parameter int SECT_PER_TRACK = 63,
  parameter int CAPACITY       = 65536,
  parameter bit PACKET_DEV     = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        xferDone,
  input  logic        bmIntClr,
  output logic        startReq,
  output logic [31:0] startLba,
  output logic [16:0] startCount,
  output logic        startWrite,
  output logic        irq,
  output logic        bmIntFlag
);

  localparam int LBA_W = 32;
  localparam int CNT_W = 17;

  tfStrobes_t       str;
  logic [7:0]       statusQ;
  logic [LBA_W-1:0] addr28, addr48;
  logic [CNT_W-1:0] cnt28, cnt48;
  logic             oor28, oor48;

  ata_tf_datapath #(
    .HEADS(HEADS), .SECT_PER_TRACK(SECT_PER_TRACK), .CAPACITY(CAPACITY),
    .PACKET_DEV(PACKET_DEV), .LBA_W(LBA_W), .CNT_W(CNT_W)
  ) dp (
    .clk(clk), .rst(rst), .str(str), .wrData(busWrData), .rdAddr(busAddr),
    .statusIn(statusQ), .rdData(busRdData), .addr28(addr28), .addr48(addr48),
    .cnt28(cnt28), .cnt48(cnt48), .oor28(oor28), .oor48(oor48)
  );

  ata_tf_control #(.LBA_W(LBA_W), .CNT_W(CNT_W)) ctl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .xferDone(xferDone), .bmIntClr(bmIntClr),
    .addr28(addr28), .addr48(addr48), .cnt28(cnt28), .cnt48(cnt48),
    .oor28(oor28), .oor48(oor48), .str(str), .statusQ(statusQ),
    .startReq(startReq), .startLba(startLba), .startCount(startCount),
    .startWrite(startWrite), .irqQ(irq), .bmFlag(bmIntFlag)
  );

endmodule

// File: tb/ata_taskfile_ctrl_test.sv
`timescale 1ns/1ps
module ata_taskfile_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        xferDone = 1'b0, bmIntClr = 1'b0;
  logic        startReq, startWrite, irq, bmIntFlag;
  logic [31:0] startLba;
  logic [16:0] startCount;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ata_taskfile_ctrl uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .xferDone(xferDone),
    .bmIntClr(bmIntClr), .startReq(startReq), .startLba(startLba),
    .startCount(startCount), .startWrite(startWrite), .irq(irq),
    .bmIntFlag(bmIntFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic wr2(input logic [3:0] a, input logic [7:0] hi, input logic [7:0] lo);
    wr(a, hi);
    wr(a, lo);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'hE, v); chk("R1 status", v, 8'h50);
    rd(4'h2, v); chk("R1 count", v, 8'h00);
    rd(4'h6, v); chk("R1 drive", v, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 startReq", startReq, 0);
    chk("R1 bmIntFlag", bmIntFlag, 0);
  endtask

  task automatic t_shift();
    logic [7:0] v;
    wr(4'h2, 8'h11); wr(4'h2, 8'h22);
    rd(4'h2, v); chk("R2 newest byte", v, 8'h22);
  endtask

  task automatic t_maskAbort();
    logic [7:0] v;
    wr(4'h7, 8'h00);
    chk("R10 masked nop irq", irq, 0);
    wr(4'h7, 8'hFF);
    rd(4'h1, v); chk("R13 abort error", v, 8'h04);
    chk("R13 abort no irq", irq, 0);
    wr(4'hE, 8'h00);
    wr(4'h7, 8'hFF);
    chk("R13 abort no irq unmasked", irq, 0);
    wr(4'h7, 8'h00);
    chk("R10 nop irq", irq, 1);
    chk("R11 bm flag set", bmIntFlag, 1);
    rd(4'hE, v);
    chk("R10 alt read keeps irq", irq, 1);
    rd(4'h7, v);
    chk("R10 status read clears irq", irq, 0);
    chk("R11 flag held", bmIntFlag, 1);
    @(negedge clk); bmIntClr = 1'b1; @(negedge clk); bmIntClr = 1'b0;
    chk("R11 flag cleared", bmIntFlag, 0);
  endtask

  task automatic t_diag();
    logic [7:0] v;
    wr(4'h7, 8'h90);
    rd(4'h1, v); chk("R13 diag error", v, 8'h01);
    chk("R13 diag irq", irq, 1);
    rd(4'h7, v); chk("R13 diag status", v, 8'h50);
  endtask

  task automatic t_drive();
    logic [7:0] v;
    wr(4'h6, 8'h50);
    rd(4'h6, v); chk("R12 slave ignored", v, 8'h00);
    wr(4'h6, 8'hE3);
    rd(4'h6, v); chk("R12 drive stored", v, 8'hE3);
  endtask

  task automatic t_lba28Read();
    logic [7:0] v;
    wr(4'h6, 8'h4F);
    wr2(4'h2, 8'h00, 8'h04); wr2(4'h3, 8'h00, 8'h10);
    wr2(4'h4, 8'h00, 8'h20); wr2(4'h5, 8'h00, 8'h00);
    wr(4'h7, 8'h20);
    chk("R7 startReq", startReq, 1);
    chk("R3 lba28", startLba, 32'h2010);
    chk("R7 count", startCount, 4);
    chk("R7 dir", startWrite, 0);
    rd(4'hE, v); chk("R7 busy", v, 8'h80);
    chk("R7 single pulse", startReq, 0);
    chk("R7 no irq before done", irq, 0);
    done();
    rd(4'hE, v); chk("R7 drq after done", v, 8'h58);
    chk("R7 irq after done", irq, 1);
    rd(4'h7, v);
  endtask

  task automatic t_chs();
    logic [7:0] v;
    wr(4'h6, 8'hA3);
    wr2(4'h3, 8'h00, 8'h05); wr2(4'h4, 8'h00, 8'h02); wr2(4'h5, 8'h00, 8'h00);
    wr2(4'h2, 8'h00, 8'h00);
    wr(4'h7, 8'h20);
    chk("R4 chs addr", startLba, 32'd2209);
    chk("R5 count zero 28", startCount, 17'd256);
    done(); rd(4'h7, v);
  endtask

  task automatic t_lba48Write();
    logic [7:0] v;
    wr(4'h6, 8'h40);
    wr2(4'h3, 8'h00, 8'h00); wr2(4'h4, 8'h00, 8'h00); wr2(4'h5, 8'h00, 8'h00);
    wr2(4'h2, 8'h00, 8'h00);
    wr(4'h7, 8'h34);
    chk("R8 startReq", startReq, 1);
    chk("R5 count zero 48", startCount, 17'd65536);
    chk("R8 dir", startWrite, 1);
    chk("R8 irq", irq, 1);
    rd(4'hE, v); chk("R8 alt no install", v, 8'h50);
    rd(4'h7, v); chk("R8 first status", v, 8'h50);
    rd(4'h7, v); chk("R8 pending installed", v, 8'h58);
    done();
    rd(4'h7, v); chk("R8 done status", v, 8'h50);
  endtask

  task automatic t_lba48Range();
    logic [7:0] v;
    wr2(4'h2, 8'h00, 8'h01);
    wr2(4'h3, 8'h01, 8'h00);
    wr(4'h7, 8'h24);
    chk("R5 prev byte used, R6 reject", startReq, 0);
    rd(4'hE, v); chk("R6 range status 48", v, 8'hFF);
    chk("R6 range irq", irq, 1);
    rd(4'h7, v);
    wr(4'h7, 8'h20);
    chk("R3 28-bit ignores history", startReq, 1);
    chk("R3 lba28 zero", startLba, 0);
    done(); rd(4'h7, v);
  endtask

  task automatic t_boundary();
    logic [7:0] v;
    wr(4'h3, 8'hFF); wr(4'h4, 8'hFF); wr(4'h5, 8'h00);
    wr(4'h2, 8'h01);
    wr(4'h7, 8'h20);
    chk("R6 ends at capacity accepted", startReq, 1);
    chk("R6 lba", startLba, 32'hFFFF);
    done(); rd(4'h7, v);
    wr(4'h2, 8'h02);
    wr(4'h7, 8'h20);
    chk("R6 one past rejected", startReq, 0);
    rd(4'h7, v); chk("R6 status", v, 8'hFF);
  endtask

  task automatic t_softReset();
    logic [7:0] v;
    wr(4'hE, 8'h04);
    rd(4'hE, v); chk("R9 status", v, 8'h51);
    rd(4'h2, v); chk("R9 count", v, 8'h01);
    rd(4'h3, v); chk("R9 low", v, 8'h01);
    rd(4'h4, v); chk("R9 mid", v, 8'h3C);
    rd(4'h5, v); chk("R9 high", v, 8'hC3);
    wr(4'hE, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_shift();
    t_maskAbort();
    t_diag();
    t_drive();
    t_lba28Read();
    t_chs();
    t_lba48Write();
    t_lba48Range();
    t_boundary();
    t_softReset();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule